// File: doc/BRIEF.md
# Digital potentiometer wiper controller

This block is the digital control section of a 100-tap digitally controlled potentiometer. Three asynchronous control lines set the wiper position. The lines are an active-low chip select, an increment strobe and an up/down direction level. The position lives in a 7-bit saturating counter. A decoder turns the counter into a one-hot tap-select vector that drives the analog transfer gates outside this block.

A nonvolatile position register is modelled as a plain register with a programmable write delay. The register is written when the device is deselected while the increment line is high. Its value is loaded back into the counter after a reset, once a synchronized power-good indication is seen. The register is cleared to a parameter value only by a power-on reset. A busy output covers the write delay. A standby output marks the idle, deselected state.

Top module: `dpot_ctrl`

## Requirements
- R1: While reset is applied and after it is released, with power-good low, pos_o is 0, tap_sel_o bit 0 is the only bit set, and busy_o and standby_o are both low.
- R2: After reset, once pwr_good_i is high, pos_o is loaded from the nonvolatile register and standby_o goes high. After a power-on reset that register holds NV_INIT, which is 50 by default.
- R3: With cs_ni low, each falling edge of inc_i moves pos_o one step. The step is up (+1) if up_i is 1 at that edge and down (-1) if up_i is 0. A rising edge of inc_i has no effect.
- R4: pos_o saturates. A step up at 99 leaves 99, and a step down at 0 leaves 0, with no wrap.
- R5: While cs_ni is high, falling edges of inc_i do not change pos_o.
- R6: A rising edge of cs_ni while inc_i is high starts a store. busy_o is high for STORE_CYCLES cycles. When it ends, the nonvolatile register holds the position and standby_o is high.
- R7: A rising edge of cs_ni while inc_i is low performs no store. The register keeps its old value, busy_o stays low and standby_o goes high.
- R8: Falling edges of inc_i that occur while busy_o is high do not change pos_o, even with cs_ni low.
- R9: The nonvolatile register keeps its value across rst_ni. Only por_ni resets it.
- R10: tap_sel_o has exactly one bit set, and it is bit number pos_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the control logic |
| por_ni | input | 1 | Active-low power-on reset; also clears the nonvolatile register |
| pwr_good_i | input | 1 | Supply-at-final-value indication, asynchronous |
| cs_ni | input | 1 | Active-low chip select, asynchronous |
| inc_i | input | 1 | Increment strobe; acts on its falling edge, asynchronous |
| up_i | input | 1 | Step direction, 1 = up, asynchronous |
| pos_o | output | 7 | Current wiper position 0..99 |
| tap_sel_o | output | 100 | One-hot tap select |
| busy_o | output | 1 | Store in progress |
| standby_o | output | 1 | Deselected idle state |

## Verification
A wrong counter value shows on pos_o and tap_sel_o three clock cycles after the increment edge, because every input passes through two synchronizer flops and one edge-detect register. A wrong stored value stays hidden until the next reset. The stored value is therefore checked by resetting the block and reading the recalled position once power-good is raised. A missed or unwanted store shows on busy_o within three cycles of the deselect. A wrong store length shows on busy_o or standby_o when STORE_CYCLES ends.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic [1:0] {
    ST_RECALL  = 2'd0,
    ST_STANDBY = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_STORE   = 2'd3
  } dpot_state_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dpot_counter.sv
module dpot_counter #(
  parameter int TAPS  = 100,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [POS_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             up_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] MaxPos = POS_W'(TAPS - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (load_i) begin
      pos_d = (load_val_i > MaxPos) ? MaxPos : load_val_i;
    end else if (step_i) begin
      if (up_i && pos_q != MaxPos) pos_d = pos_q + POS_W'(1);
      else if (!up_i && pos_q != '0) pos_d = pos_q - POS_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= MaxPos);

  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && up_i && pos_q < MaxPos) |=> pos_q == $past(pos_q) + POS_W'(1));

  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !up_i && pos_q != '0) |=> pos_q == $past(pos_q) - POS_W'(1));

  assert_sat_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && up_i && pos_q == MaxPos) |=> $stable(pos_q));

  assert_sat_bottom_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !up_i && pos_q == '0) |=> $stable(pos_q));
endmodule

// File: rtl/dpot_nv.sv
module dpot_nv #(
  parameter int POS_W        = 7,
  parameter int STORE_CYCLES = 40,
  parameter int NV_INIT      = 50,
  localparam int CntW        = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             start_i,
  input  logic [POS_W-1:0] data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [POS_W-1:0] q_o
);
  logic [CntW-1:0]  cnt_q;
  logic [POS_W-1:0] data_q;
  logic [POS_W-1:0] cell_q;
  logic             last;

  assign last   = (cnt_q == CntW'(1));
  assign busy_o = (cnt_q != '0);
  assign done_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (start_i && !busy_o) begin
      cnt_q  <= CntW'(STORE_CYCLES);
      data_q <= data_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CntW'(1);
    end
  end

  // cell survives rst_ni, cleared only on power-on
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)               cell_q <= POS_W'(NV_INIT);
    else if (rst_ni && last)   cell_q <= data_q;
  end

  assign q_o = cell_q;

  assert_cell_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !busy_o |=> $stable(cell_q));

  assert_start_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_write_val_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    last |=> cell_q == $past(data_q));
endmodule

// File: rtl/dpot_decode.sv
module dpot_decode #(
  parameter int TAPS  = 100,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  output logic [TAPS-1:0]  tap_sel_o
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel_o[i] = (pos_i == POS_W'(i));
  end

  assert_one_hot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_sel_o) == 1);
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
  parameter int TAPS         = 100,
  parameter int STORE_CYCLES = 40,
  parameter int NV_INIT      = 50,
  localparam int PosW        = $clog2(TAPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            por_ni,
  input  logic            pwr_good_i,
  input  logic            cs_ni,
  input  logic            inc_i,
  input  logic            up_i,
  output logic [PosW-1:0] pos_o,
  output logic [TAPS-1:0] tap_sel_o,
  output logic            busy_o,
  output logic            standby_o
);
  import dpot_pkg::*;

  logic core_rst_n;
  assign core_rst_n = rst_ni & por_ni;

  // bit order: pwr_good, up, inc, cs
  logic [3:0] raw, syn;
  logic       cs_s, inc_s, up_s, pg_s;
  assign raw = {pwr_good_i, up_i, inc_i, cs_ni};

  dpot_sync #(.W(4), .RST_VAL(4'b0011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (core_rst_n),
    .d_i    (raw),
    .q_o    (syn)
  );
  assign {pg_s, up_s, inc_s, cs_s} = syn;

  logic cs_prev_q, inc_prev_q;
  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cs_prev_q  <= 1'b1;
      inc_prev_q <= 1'b1;
    end else begin
      cs_prev_q  <= cs_s;
      inc_prev_q <= inc_s;
    end
  end

  logic inc_fall, cs_rise;
  assign inc_fall = inc_prev_q & ~inc_s;
  assign cs_rise  = ~cs_prev_q & cs_s;

  dpot_state_e state_q, state_d;
  logic            load, step, nv_start, nv_busy, nv_done;
  logic [PosW-1:0] nv_q, pos;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    step     = 1'b0;
    nv_start = 1'b0;
    unique case (state_q)
      ST_RECALL: if (pg_s) begin
        load    = 1'b1;
        state_d = ST_STANDBY;
      end
      ST_STANDBY: if (!cs_s) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        if (cs_rise) begin
          if (inc_s) begin
            nv_start = 1'b1;
            state_d  = ST_STORE;
          end else begin
            state_d  = ST_STANDBY;
          end
        end else if (inc_fall && !cs_s) begin
          step = 1'b1;
        end
      end
      ST_STORE: if (nv_done) state_d = ST_STANDBY;
      default: state_d = ST_RECALL;
    endcase
  end

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) state_q <= ST_RECALL;
    else             state_q <= state_d;
  end

  dpot_counter #(.TAPS(TAPS), .POS_W(PosW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (core_rst_n),
    .load_i     (load),
    .load_val_i (nv_q),
    .step_i     (step),
    .up_i       (up_s),
    .pos_o      (pos)
  );

  dpot_nv #(.POS_W(PosW), .STORE_CYCLES(STORE_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .por_ni  (por_ni),
    .start_i (nv_start),
    .data_i  (pos),
    .busy_o  (nv_busy),
    .done_o  (nv_done),
    .q_o     (nv_q)
  );

  dpot_decode #(.TAPS(TAPS), .POS_W(PosW)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (core_rst_n),
    .pos_i     (pos),
    .tap_sel_o (tap_sel_o)
  );

  assign pos_o     = pos;
  assign busy_o    = nv_busy;
  assign standby_o = (state_q == ST_STANDBY);

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    busy_o |=> $stable(pos));

  assert_deselect_hold_R5: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (state_q == ST_STANDBY) |=> $stable(pos));

  assert_no_store_R7: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (state_q == ST_ACTIVE && cs_rise && !inc_s) |=> (standby_o && !busy_o));

  assert_store_state_R6: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    busy_o |-> (state_q == ST_STORE));

  assert_recall_wait_R2: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (state_q == ST_RECALL && !pg_s) |=> (pos == $past(pos)));
endmodule

// File: tb/dpot_ctrl_tb.sv
`timescale 1ns/1ps
module dpot_ctrl_tb;
  localparam int TAPS = 100;
  localparam int SC   = 40;
  localparam int INIT = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0, pg = 1'b0, cs_n = 1'b1, inc = 1'b1, up = 1'b0;
  logic [6:0]      pos;
  logic [TAPS-1:0] tap;
  logic            busy, stby;

  int checks = 0, errors = 0;
  int exp_pos = 0, exp_nv = INIT;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dpot_ctrl #(.TAPS(TAPS), .STORE_CYCLES(SC), .NV_INIT(INIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .pwr_good_i(pg),
    .cs_ni(cs_n), .inc_i(inc), .up_i(up),
    .pos_o(pos), .tap_sel_o(tap), .busy_o(busy), .standby_o(stby)
  );

  function automatic int step_model(int p, bit dir);
    if (dir)  return (p < TAPS - 1) ? p + 1 : p;
    else      return (p > 0) ? p - 1 : p;
  endfunction

  function automatic logic [TAPS-1:0] onehot(int p);
    logic [TAPS-1:0] v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(string req);
    chk(pos == 7'(exp_pos), req, int'(pos), exp_pos);
    chk(tap == onehot(exp_pos), "R10", int'(tap == onehot(exp_pos)), 1);
  endtask

  task automatic pulse(bit dir, bit active);
    up = dir; cyc(4);
    inc = 1'b0; cyc(4);
    if (active) exp_pos = step_model(exp_pos, dir);
    inc = 1'b1; cyc(4);
  endtask

  task automatic reset_recall(bit power);
    cs_n = 1'b1; inc = 1'b1; pg = 1'b0;
    rst_n = 1'b0; if (power) por_n = 1'b0;
    cyc(3);
    rst_n = 1'b1; por_n = 1'b1;
    if (power) exp_nv = INIT;
    exp_pos = 0;
    cyc(5);
    chk_pos("R1");
    chk(!busy && !stby, "R1", int'({busy, stby}), 0);
    pg = 1'b1; cyc(6);
    exp_pos = exp_nv;
    chk_pos("R2");
    chk(stby == 1'b1, "R2", int'(stby), 1);
  endtask

  task automatic store_seq();
    cs_n = 1'b1; cyc(4);
    chk(busy == 1'b1, "R6", int'(busy), 1);
    cyc(SC + 4);
    exp_nv = exp_pos;
    chk(!busy && stby, "R6", int'({busy, stby}), 1);
    cs_n = 1'b0; cyc(4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    reset_recall(1'b1);

    cs_n = 1'b0; cyc(4);
    pulse(1'b1, 1'b1); chk_pos("R3");
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); chk_pos("R3");
    // rising edge alone: no step
    inc = 1'b0; cyc(4); exp_pos = step_model(exp_pos, up);
    chk_pos("R3");
    inc = 1'b1; cyc(5); chk_pos("R3");

    for (int i = 0; i < 60; i++) pulse(1'b1, 1'b1);
    chk(pos == 7'd99, "R4", int'(pos), 99); chk_pos("R4");
    store_seq();
    reset_recall(1'b0);
    chk(pos == 7'd99, "R9", int'(pos), 99);

    cs_n = 1'b0; cyc(4);
    for (int i = 0; i < 105; i++) pulse(1'b0, 1'b1);
    chk(pos == 7'd0, "R4", int'(pos), 0); chk_pos("R4");
    pulse(1'b1, 1'b1); pulse(1'b1, 1'b1); chk_pos("R3");

    // deselect with inc low: no store
    inc = 1'b0; cyc(4); exp_pos = step_model(exp_pos, up);
    cs_n = 1'b1; cyc(4);
    chk(!busy && stby, "R7", int'({busy, stby}), 1);
    pulse(1'b1, 1'b0); chk_pos("R5");
    pulse(1'b0, 1'b0); chk_pos("R5");
    reset_recall(1'b0);
    chk(pos == 7'd99, "R7", int'(pos), 99);

    // inc edges during store are ignored
    cs_n = 1'b0; cyc(4);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    cs_n = 1'b1; cyc(4);
    chk(busy == 1'b1, "R6", int'(busy), 1);
    cs_n = 1'b0; cyc(2);
    up = 1'b0; inc = 1'b0; cyc(3); inc = 1'b1; cyc(3);
    chk(busy == 1'b1, "R8", int'(busy), 1);
    chk_pos("R8");
    cyc(SC);
    exp_nv = exp_pos;
    chk_pos("R8");
    chk(!busy, "R6", int'(busy), 0);

    // random phase
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom_range(0, 15));
      if (r == 0) begin
        store_seq();
      end else if (r == 1) begin
        cs_n = 1'b1; cyc(4);
        pulse(1'($urandom_range(0, 1)), 1'b0);
        chk_pos("R5");
        // cs high with inc high is a store
        exp_nv = exp_pos;
        cyc(SC + 4);
        cs_n = 1'b0; cyc(4);
      end else begin
        pulse(1'($urandom_range(0, 1)), 1'b1);
        chk_pos("R3");
      end
    end

    reset_recall(1'b0);
    reset_recall(1'b1);
    chk(pos == 7'(INIT), "R9", int'(pos), INIT);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule